// File: doc/BRIEF.md
# DPLL Lock Status Aggregator

This block condenses the health of a secondary digital PLL into one lock bit. Four loss-of-phase indicators feed it: a fine phase detector, a coarse detector that flags cycle slips, a monitor that reports no activity on the input, and a flag raised when the loop sits at either end of its frequency range. Each indicator has its own enable input, driven from a control register. A source whose enable is 0 has no effect on the result. The lock bit is registered and reads 1 when the loop is locked and 0 when it is not.

The coarse source behaves differently from the other three. A single asserted cycle of the coarse indicator, seen while its enable is 1, is held in a latch. That latch keeps the lock bit at 0 after the slips have stopped. The latch empties in any cycle in which the coarse enable is 0. Software reads the current state by clearing the coarse enable, sampling the lock bit and then setting the enable again. A lock bit that already reads 1 is always current and needs no such sequence. The other three sources act on the bit only while they are asserted.

Top module: `lock_status_agg`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `locked` reads 1. Reset also empties the coarse latch.
- R2: The fine source is `loss_raw[0]`, gated by `loss_enable[0]`. When both are 1 at a clock edge, `locked` is 0 after that edge. While `loss_enable[0]` is 0, `loss_raw[0]` has no effect.
- R3: The input-activity source is `loss_raw[2]`, gated by `loss_enable[2]`. It follows the same rule as R2.
- R4: The frequency-limit source is `loss_raw[3]`, gated by `loss_enable[3]`. It follows the same rule as R2.
- R5: The coarse source is `loss_raw[1]`, gated by `loss_enable[1]`. If both are 1 at an edge, `locked` becomes 0 after that edge. It then stays 0 for as long as `loss_enable[1]` remains 1, even after `loss_raw[1]` has returned to 0.
- R6: At any edge where `loss_enable[1]` is 0, the coarse latch is emptied and `loss_raw[1]` is ignored. This includes an edge at which `loss_raw[1]` is 1 in the same cycle that the enable drops. After such an edge, `locked` depends only on the other three sources.
- R7: `locked` is registered with a latency of one cycle. After each edge it equals the inverse of the OR of two terms: the enabled live sources (bits 0, 2 and 3) sampled at that edge, and the state of the coarse latch after that edge.
- R8: Setting `loss_enable[1]` back to 1 while `loss_raw[1]` is 0 keeps `locked` at 1, provided no other enabled source is active.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| loss_raw | input | NSRC (4) | Live phase-loss indicators: bit 0 fine, bit 1 coarse (cycle slip), bit 2 no input activity, bit 3 frequency limit |
| loss_enable | input | NSRC (4) | Per-source enables from the control register, same bit order as `loss_raw` |
| locked | output | 1 | Registered lock status: 1 locked, 0 not locked |

## Verification
The hardest situation to reach is a coarse pulse that arrives in the same cycle the coarse enable is cleared. It must be dropped rather than latched. The stimulus first latches a slip, then drives the disable and a fresh coarse pulse together at one edge. It then re-enables with the indicator quiet and expects the lock bit to return and stay at 1. A long run of random enable and indicator patterns, compared against a behavioural model on every clock, also passes through the latch-and-recover paths under many combinations with the live sources.

// File: rtl/lockagg_pkg.sv
package lockagg_pkg;

   typedef enum int unsigned {
      SRC_FINE     = 0,
      SRC_COARSE   = 1,
      SRC_ACTIVITY = 2,
      SRC_FLIMIT   = 3
   } src_e;

   localparam int unsigned NSRC_DEFAULT = 4;

endpackage

// File: rtl/lockagg_sticky.sv
// Latching loss source: set by an enabled indicator, emptied while disabled.
module lockagg_sticky (
   input  logic clk,
   input  logic rst,
   input  logic raw,
   input  logic en,
   output logic loss,
   output logic held
);

   logic held_d;

   // A disabled source always clears; clearing wins over a coincident pulse.
   always_comb begin
      if (!en) held_d = 1'b0;
      else     held_d = held | raw;
   end

   always_ff @(posedge clk) begin
      if (rst) held <= 1'b0;
      else     held <= held_d;
   end

   // The contribution reflects the state the latch takes at this edge.
   assign loss = held_d;

endmodule

// File: rtl/lockagg_combine.sv
// Reduces the per-source loss terms into the registered lock bit.
module lockagg_combine #(
   parameter int unsigned NSRC = 4
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] loss_vec,
   output logic            locked
);

   logic any_loss;

   assign any_loss = |loss_vec;

   always_ff @(posedge clk) begin
      if (rst) locked <= 1'b1;
      else     locked <= ~any_loss;
   end

endmodule

// File: rtl/lock_status_agg.sv
module lock_status_agg #(
   parameter int unsigned NSRC       = lockagg_pkg::NSRC_DEFAULT,
   parameter int unsigned STICKY_IDX = int'(lockagg_pkg::SRC_COARSE)
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NSRC-1:0] loss_raw,
   input  logic [NSRC-1:0] loss_enable,
   output logic            locked
);

   localparam int unsigned IDX_W = (NSRC > 1) ? $clog2(NSRC) : 1;

   if (NSRC < 1) begin : g_chk_nsrc
      $error("lock_status_agg: NSRC must be at least 1");
   end
   if (STICKY_IDX >= NSRC) begin : g_chk_idx
      $error("lock_status_agg: STICKY_IDX out of range");
   end

   logic [NSRC-1:0] loss_vec;
   logic [NSRC-1:0] held_vec;
   logic            coarse_held;

   for (genvar i = 0; i < NSRC; i++) begin : g_src
      if (i == STICKY_IDX) begin : g_sticky
         lockagg_sticky u_sticky (
            .clk  (clk),
            .rst  (rst),
            .raw  (loss_raw[i]),
            .en   (loss_enable[i]),
            .loss (loss_vec[i]),
            .held (held_vec[i])
         );
      end else begin : g_live
         assign loss_vec[i] = loss_raw[i] & loss_enable[i];
         assign held_vec[i] = 1'b0;
      end
   end

   // Only the sticky slot can be nonzero.
   assign coarse_held = |held_vec;

   lockagg_combine #(.NSRC(NSRC)) u_combine (
      .clk      (clk),
      .rst      (rst),
      .loss_vec (loss_vec),
      .locked   (locked)
   );

   logic [IDX_W-1:0] unused_idx;
   assign unused_idx = IDX_W'(STICKY_IDX);

endmodule

// File: rtl/lock_status_agg_chk.sv
module lock_status_agg_chk #(
   parameter int unsigned NSRC       = 4,
   parameter int unsigned STICKY_IDX = 1
) (
   input logic            clk,
   input logic            rst,
   input logic [NSRC-1:0] loss_raw,
   input logic [NSRC-1:0] loss_enable,
   input logic            locked,
   input logic            held
);

   logic [NSRC-1:0] live_mask;
   always_comb begin
      live_mask = '1;
      live_mask[STICKY_IDX] = 1'b0;
   end

   a_r1_reset_locked: assert property (@(posedge clk) disable iff (rst)
      $past(rst) |-> locked);

   a_r2_fine_loss: assert property (@(posedge clk) disable iff (rst)
      (loss_raw[0] && loss_enable[0]) |=> !locked);

   a_r3_activity_loss: assert property (@(posedge clk) disable iff (rst)
      (loss_raw[2] && loss_enable[2]) |=> !locked);

   a_r4_flimit_loss: assert property (@(posedge clk) disable iff (rst)
      (loss_raw[3] && loss_enable[3]) |=> !locked);

   a_r5_coarse_hold: assert property (@(posedge clk) disable iff (rst)
      (held && loss_enable[STICKY_IDX]) |=> (held && !locked));

   a_r6_clear_when_off: assert property (@(posedge clk) disable iff (rst)
      !loss_enable[STICKY_IDX] |=> !held);

   a_r7_quiet_locks: assert property (@(posedge clk) disable iff (rst)
      (((loss_raw & loss_enable & live_mask) == '0) && !loss_enable[STICKY_IDX]) |=> locked);

endmodule

bind lock_status_agg lock_status_agg_chk #(.NSRC(NSRC), .STICKY_IDX(STICKY_IDX)) u_chk (
   .clk         (clk),
   .rst         (rst),
   .loss_raw    (loss_raw),
   .loss_enable (loss_enable),
   .locked      (locked),
   .held        (coarse_held)
);

// File: tb/lock_status_agg_test.sv
module lock_status_agg_test;

   localparam time CLK_PERIOD = 10ns;
   localparam int  WATCHDOG   = 5000;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [3:0] loss_raw = '0;
   logic [3:0] loss_enable = '0;
   logic       locked;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done = 0;

   // Behavioural reference state.
   bit ref_latched = 0;
   bit ref_locked  = 1;

   lock_status_agg uut (
      .clk         (clk),
      .rst         (rst),
      .loss_raw    (loss_raw),
      .loss_enable (loss_enable),
      .locked      (locked)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      bit live;
      cycles++;
      if (rst) begin
         ref_latched = 0;
         ref_locked  = 1;
      end else begin
         live = (loss_raw[0] && loss_enable[0]) ||
                (loss_raw[2] && loss_enable[2]) ||
                (loss_raw[3] && loss_enable[3]);
         if (loss_enable[1] == 1'b0) ref_latched = 0;
         else if (loss_raw[1])       ref_latched = 1;
         ref_locked = !(live || ref_latched);
      end
   end

   task automatic step(input bit r, input logic [3:0] raw,
                       input logic [3:0] en, input string tag);
      @(negedge clk);
      rst = r;
      loss_raw = raw;
      loss_enable = en;
      @(negedge clk);
      checks++;
      if (locked !== ref_locked) begin
         errors++;
         $display("FAIL %s: raw=%b en=%b locked actual=%b expected=%b",
                  tag, raw, en, locked, ref_locked);
      end
   endtask

   initial begin
      // R1: reset state
      step(1, 4'h0, 4'h0, "R1");
      step(1, 4'hF, 4'hF, "R1");
      step(0, 4'h0, 4'hF, "R1");
      step(0, 4'h0, 4'hF, "R7");
      // R2: fine source
      step(0, 4'b0001, 4'hF, "R2");
      step(0, 4'b0000, 4'hF, "R2");
      step(0, 4'b0001, 4'b1110, "R2");
      // R3: activity source
      step(0, 4'b0100, 4'hF, "R3");
      step(0, 4'b0000, 4'hF, "R3");
      step(0, 4'b0100, 4'b1011, "R3");
      // R4: frequency-limit source
      step(0, 4'b1000, 4'hF, "R4");
      step(0, 4'b0000, 4'hF, "R4");
      step(0, 4'b1000, 4'b0111, "R4");
      // R5: single-cycle slip is latched
      step(0, 4'b0010, 4'hF, "R5");
      for (int i = 0; i < 3; i++) step(0, 4'b0000, 4'hF, "R5");
      // R6: disable clears, indicator ignored while disabled
      step(0, 4'b0000, 4'b1101, "R6");
      step(0, 4'b0010, 4'b1101, "R6");
      // R8: re-enable with quiet indicator
      step(0, 4'b0000, 4'hF, "R8");
      step(0, 4'b0000, 4'hF, "R8");
      // R6: coincident pulse with the disable is dropped
      step(0, 4'b0010, 4'hF, "R5");
      step(0, 4'b0010, 4'b1101, "R6");
      step(0, 4'b0000, 4'hF, "R8");
      // R6: cleared latch leaves live sources in charge
      step(0, 4'b0010, 4'hF, "R5");
      step(0, 4'b0001, 4'b1101, "R6");
      step(0, 4'b0000, 4'b1101, "R6");
      // R1: reset empties a held latch
      step(0, 4'b0010, 4'hF, "R5");
      step(1, 4'b0000, 4'hF, "R1");
      step(0, 4'b0000, 4'hF, "R1");
      // R7: random patterns against the model
      for (int i = 0; i < 300; i++) begin
         logic [3:0] rr, ee;
         rr = 4'($urandom);
         ee = 4'($urandom);
         if (($urandom % 4) != 0) rr = rr & 4'($urandom);
         step(0, rr, ee, "R7");
      end
      done = 1;
   end

   initial begin
      while (!done && cycles < WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: cycles actual=%0d expected<%0d", cycles, WATCHDOG);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule